// File: doc/BRIEF.md
# Serial Audio Port Interrupt Flag Controller

This block gathers the status of a full-duplex serial audio port and turns it into a single interrupt request. The datapath reports two kinds of information. Live levels (packet ready, transmit space, duplex packet, transmit complete, receive packing level, partial receive word) pass straight into the status word. One-cycle event strobes (end of transfer, transfer filled, underrun, overrun, CRC error, frame error, mode fault, size reload, suspended) are captured as sticky flags that stay set until software clears them.

Software uses a small register port with three addresses. Address 0 reads the 16-bit status word. Address 1 reads and writes the 11-bit interrupt enable word. Address 2 is a write-one-to-clear register for the sticky flags. At stream start, driver code writes ones to all clearable positions. The interrupt output is a registered OR of the enabled status bits.

Top module: `irqf_ctrl`

## Requirements
- R1: After reset every sticky flag is 0, the enable word reads 0 and `irq` is 0.
- R2: Status bits 0 (`lvl_lo[0]`, receive packet ready), 1 (`lvl_lo[1]`, transmit space), 2 (`lvl_lo[2]`, duplex packet), 12 (`tx_cmpl`), 14:13 (`rx_lvl`) and 15 (`rx_part`) follow their inputs in the same cycle, with no storage.
- R3: A 1 on `evt[i]` at a clock edge sets sticky status bit 3+i (bits 3 to 11). The bit then stays set with no further event.
- R4: Writing to address 2 clears every sticky bit (3 to 11) whose `wdata` bit is 1. Zero bits in the write have no effect. Set bits at positions 0 to 2 and 12 to 15 have no effect either.
- R5: When an event and a clear for the same sticky bit fall in the same cycle, the event wins and the bit stays 1.
- R6: Writing to address 1 loads `wdata[10:0]` as the enable word. Reading address 1 returns the enable word in bits 10:0, with bits 15:11 at 0.
- R7: `irq` is 1 exactly one cycle after any cycle in which status bits 10:0 ANDed with the enable word are nonzero. It is 0 one cycle after they are all zero. This applies to flag changes, level changes and enable changes.
- R8: A write to address 0 leaves the status unchanged. Reads of address 2 and address 3 return 0.
- R9: Status bit 11 (suspended) has no enable position and never raises `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lvl_lo | input | 3 | Live levels for status bits 2:0 |
| evt | input | 9 | Event strobes; bit i sets status bit 3+i |
| tx_cmpl | input | 1 | Transmit complete level, status bit 12 |
| rx_lvl | input | 2 | Receive packing level, status bits 14:13 |
| rx_part | input | 1 | Partial receive word level, status bit 15 |
| wr | input | 1 | Register write strobe |
| addr | input | 2 | Register address: 0 status, 1 enable, 2 clear |
| wdata | input | 16 | Register write data |
| rdata | output | 16 | Register read data for `addr`, combinational |
| irq | output | 1 | Registered interrupt request |

## Verification
An event strobe and a software clear of the same sticky flag can arrive in the same cycle. The bench drives `evt` and a clear write on one falling edge and then reads the status back. The flag must still be set, because the event has priority. In the same test, a clear aimed at a different flag must still take effect. The bench also checks `irq` on the first and second falling edges after a flag, level or enable change, which pins the single register stage of latency.

// File: rtl/irqf_pkg.sv
package irqf_pkg;

   typedef enum logic [1:0] {
      ADR_STATUS = 2'd0,
      ADR_ENABLE = 2'd1,
      ADR_CLEAR  = 2'd2,
      ADR_SPARE  = 2'd3
   } irqf_addr_e;

endpackage

// File: rtl/irqf_sticky.sv
module irqf_sticky #(
   parameter int unsigned N = 9
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] flag_o
);

   logic [N-1:0] flag_q;

   for (genvar i = 0; i < N; i++) begin : g_bit
      always_ff @(posedge clk) begin
         if (!rst_n)
            flag_q[i] <= 1'b0;
         else if (set_i[i])
            flag_q[i] <= 1'b1;
         else if (clr_i[i])
            flag_q[i] <= 1'b0;
      end

      p_event_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
         set_i[i] |=> flag_q[i]);

      p_event_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (set_i[i] && clr_i[i]) |=> flag_q[i]);

      p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_i[i] && !set_i[i]) |=> !flag_q[i]);

      p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (!clr_i[i] && !set_i[i]) |=> $stable(flag_q[i]));
   end

   assign flag_o = flag_q;

endmodule

// File: rtl/irqf_regport.sv
module irqf_regport
   import irqf_pkg::*;
#(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned EN_W   = 11,
   parameter int unsigned CLR_LO = 3,
   parameter int unsigned CLR_HI = 11
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr,
   input  logic [1:0]               addr,
   input  logic [DATA_W-1:0]        wdata,
   input  logic [DATA_W-1:0]        status_i,
   output logic [EN_W-1:0]          en_o,
   output logic [CLR_HI-CLR_LO:0]   clr_o,
   output logic [DATA_W-1:0]        rdata
);

   localparam int unsigned CLR_N = CLR_HI - CLR_LO + 1;

   irqf_addr_e   sel;
   logic [EN_W-1:0] en_q;
   logic         wr_en;
   logic         wr_clr;
   logic         unused_wdata;

   assign sel    = irqf_addr_e'(addr);
   assign wr_en  = wr && (sel == ADR_ENABLE);
   assign wr_clr = wr && (sel == ADR_CLEAR);

   always_ff @(posedge clk) begin
      if (!rst_n)
         en_q <= '0;
      else if (wr_en)
         en_q <= wdata[EN_W-1:0];
   end

   assign clr_o = wr_clr ? wdata[CLR_HI:CLR_LO] : {CLR_N{1'b0}};

   always_comb begin
      unique case (sel)
         ADR_STATUS: rdata = status_i;
         ADR_ENABLE: rdata = DATA_W'(en_q);
         default:    rdata = '0;
      endcase
   end

   assign en_o = en_q;

   if (DATA_W > CLR_HI + 1) begin : g_spare_bits
      assign unused_wdata = ^wdata[DATA_W-1:CLR_HI+1];
   end else begin : g_no_spare_bits
      assign unused_wdata = 1'b0;
   end

   p_enable_wr_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (en_o == $past(wdata[EN_W-1:0])));

   p_enable_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(en_o));

endmodule

// File: rtl/irqf_combine.sv
module irqf_combine #(
   parameter int unsigned EN_W = 11
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [EN_W-1:0] stat_i,
   input  logic [EN_W-1:0] en_i,
   output logic            irq_o
);

   logic hit;
   logic irq_q;

   assign hit = |(stat_i & en_i);

   always_ff @(posedge clk) begin
      if (!rst_n)
         irq_q <= 1'b0;
      else
         irq_q <= hit;
   end

   assign irq_o = irq_q;

   p_irq_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (|(stat_i & en_i)) |=> irq_o);

   p_irq_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ((stat_i & en_i) == '0) |=> !irq_o);

endmodule

// File: rtl/irqf_ctrl.sv
module irqf_ctrl #(
   parameter int unsigned STK_LO  = 3,
   parameter int unsigned STK_HI  = 11,
   parameter int unsigned EN_W    = 11,
   parameter int unsigned RXLVL_W = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [STK_LO-1:0]          lvl_lo,
   input  logic [STK_HI-STK_LO:0]     evt,
   input  logic                       tx_cmpl,
   input  logic [RXLVL_W-1:0]         rx_lvl,
   input  logic                       rx_part,
   input  logic                       wr,
   input  logic [1:0]                 addr,
   input  logic [STK_HI+RXLVL_W+2:0]  wdata,
   output logic [STK_HI+RXLVL_W+2:0]  rdata,
   output logic                       irq
);

   localparam int unsigned STK_N  = STK_HI - STK_LO + 1;
   localparam int unsigned STAT_W = STK_HI + RXLVL_W + 3;

   if (STK_LO < 1 || STK_HI < STK_LO) begin : g_bad_sticky
      $error("sticky field bounds are invalid");
   end
   if (EN_W <= STK_LO || EN_W > STK_HI + 1) begin : g_bad_enable
      $error("enable width must reach into the sticky field");
   end

   logic [STK_N-1:0]  sticky;
   logic [STK_N-1:0]  clr;
   logic [EN_W-1:0]   en;
   logic [STAT_W-1:0] status;

   irqf_sticky #(
      .N (STK_N)
   ) i_sticky (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (evt),
      .clr_i  (clr),
      .flag_o (sticky)
   );

   assign status = {rx_part, rx_lvl, tx_cmpl, sticky, lvl_lo};

   irqf_regport #(
      .DATA_W (STAT_W),
      .EN_W   (EN_W),
      .CLR_LO (STK_LO),
      .CLR_HI (STK_HI)
   ) i_regport (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (wr),
      .addr     (addr),
      .wdata    (wdata),
      .status_i (status),
      .en_o     (en),
      .clr_o    (clr),
      .rdata    (rdata)
   );

   irqf_combine #(
      .EN_W (EN_W)
   ) i_combine (
      .clk    (clk),
      .rst_n  (rst_n),
      .stat_i (status[EN_W-1:0]),
      .en_i   (en),
      .irq_o  (irq)
   );

   if (EN_W <= STK_HI) begin : g_unenabled_flags
      p_no_enable_bit_r9: assert property (@(posedge clk) disable iff (!rst_n)
         ((status[EN_W-1:0] & en) == '0) |=> !irq);
   end

endmodule

// File: tb/test_irqf_ctrl.sv
module test_irqf_ctrl;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  lvl_lo = '0;
   logic [8:0]  evt = '0;
   logic        tx_cmpl = 1'b0;
   logic [1:0]  rx_lvl = '0;
   logic        rx_part = 1'b0;
   logic        wr = 1'b0;
   logic [1:0]  addr = '0;
   logic [15:0] wdata = '0;
   logic [15:0] rdata;
   logic        irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   irqf_ctrl i_irqf_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .lvl_lo  (lvl_lo),
      .evt     (evt),
      .tx_cmpl (tx_cmpl),
      .rx_lvl  (rx_lvl),
      .rx_part (rx_part),
      .wr      (wr),
      .addr    (addr),
      .wdata   (wdata),
      .rdata   (rdata),
      .irq     (irq)
   );

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic reg_wr(input logic [1:0] a, input logic [15:0] d);
      @(negedge clk);
      wr = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr = 1'b0; wdata = '0;
   endtask

   task automatic reg_rd(input logic [1:0] a, output logic [15:0] d);
      @(negedge clk);
      addr = a;
      #1 d = rdata;
   endtask

   task automatic pulse(input logic [8:0] m);
      @(negedge clk);
      evt = m;
      @(negedge clk);
      evt = '0;
   endtask

   task automatic tidy();
      reg_wr(2'd2, 16'h0FF8);
      reg_wr(2'd1, 16'h0000);
      @(negedge clk);
   endtask

   task automatic t_reset();
      logic [15:0] d;
      reg_rd(2'd0, d); chk("R1 status after reset", d, 16'h0000);
      reg_rd(2'd1, d); chk("R1 enable after reset", d, 16'h0000);
      chk("R1 irq after reset", {15'd0, irq}, 16'h0000);
   endtask

   task automatic t_levels();
      logic [15:0] d;
      @(negedge clk);
      lvl_lo = 3'b001; tx_cmpl = 1'b1; rx_lvl = 2'b10; rx_part = 1'b1;
      reg_rd(2'd0, d); chk("R2 live levels A", d, 16'hD001);
      reg_wr(2'd2, 16'hFFFF);
      reg_rd(2'd0, d); chk("R4 clear ignores level bits", d, 16'hD001);
      @(negedge clk);
      lvl_lo = 3'b110; tx_cmpl = 1'b0; rx_lvl = 2'b01; rx_part = 1'b0;
      reg_rd(2'd0, d); chk("R2 live levels B", d, 16'h2006);
      @(negedge clk);
      lvl_lo = '0; rx_lvl = '0;
      reg_rd(2'd0, d); chk("R2 levels released", d, 16'h0000);
   endtask

   task automatic t_sticky();
      logic [15:0] d;
      pulse(9'h004);
      reg_rd(2'd0, d); chk("R3 underrun captured", d, 16'h0020);
      repeat (5) @(negedge clk);
      reg_rd(2'd0, d); chk("R3 underrun held", d, 16'h0020);
      pulse(9'h1F8);
      reg_rd(2'd0, d); chk("R3 more flags captured", d, 16'h0FE0);
      tidy();
   endtask

   task automatic t_clear();
      logic [15:0] d;
      pulse(9'h1FF);
      reg_rd(2'd0, d); chk("R3 all flags set", d, 16'h0FF8);
      reg_wr(2'd2, 16'h0000);
      reg_rd(2'd0, d); chk("R4 zero write no effect", d, 16'h0FF8);
      reg_wr(2'd2, 16'h0128);
      reg_rd(2'd0, d); chk("R4 partial clear", d, 16'h0ED0);
      reg_wr(2'd2, 16'h0FF8);
      reg_rd(2'd0, d); chk("R4 full clear", d, 16'h0000);
   endtask

   task automatic t_race();
      logic [15:0] d;
      pulse(9'h004);
      @(negedge clk);
      evt = 9'h008; wr = 1'b1; addr = 2'd2; wdata = 16'h0060;
      @(negedge clk);
      evt = '0; wr = 1'b0; wdata = '0;
      reg_rd(2'd0, d); chk("R5 event beats clear", d, 16'h0040);
      tidy();
   endtask

   task automatic t_enable();
      logic [15:0] d;
      reg_wr(2'd1, 16'hFFFF);
      reg_rd(2'd1, d); chk("R6 enable width", d, 16'h07FF);
      reg_wr(2'd1, 16'h0421);
      reg_rd(2'd1, d); chk("R6 enable pattern", d, 16'h0421);
      tidy();
   endtask

   task automatic t_irq();
      reg_wr(2'd1, 16'h0020);
      @(negedge clk);
      evt = 9'h004;
      @(negedge clk);
      evt = '0;
      #1 chk("R7 irq not yet after flag", {15'd0, irq}, 16'h0000);
      @(negedge clk);
      #1 chk("R7 irq one cycle after flag", {15'd0, irq}, 16'h0001);
      reg_wr(2'd2, 16'h0020);
      #1 chk("R7 irq held one cycle after clear", {15'd0, irq}, 16'h0001);
      @(negedge clk);
      #1 chk("R7 irq drops after clear", {15'd0, irq}, 16'h0000);
      pulse(9'h008);
      @(negedge clk);
      #1 chk("R7 masked flag no irq", {15'd0, irq}, 16'h0000);
      reg_wr(2'd1, 16'h0041);
      #1 chk("R7 irq not yet after enable", {15'd0, irq}, 16'h0000);
      @(negedge clk);
      #1 chk("R7 irq after enable", {15'd0, irq}, 16'h0001);
      reg_wr(2'd2, 16'h0040);
      repeat (2) @(negedge clk);
      lvl_lo = 3'b001;
      @(negedge clk);
      #1 chk("R7 irq from level", {15'd0, irq}, 16'h0001);
      lvl_lo = 3'b000;
      @(negedge clk);
      #1 chk("R7 irq level released", {15'd0, irq}, 16'h0000);
      tidy();
   endtask

   task automatic t_suspend();
      logic [15:0] d;
      reg_wr(2'd1, 16'h07FF);
      pulse(9'h100);
      repeat (2) @(negedge clk);
      reg_rd(2'd0, d); chk("R9 suspended flag set", d, 16'h0800);
      #1 chk("R9 suspended raises no irq", {15'd0, irq}, 16'h0000);
      tidy();
   endtask

   task automatic t_status_write();
      logic [15:0] d;
      reg_wr(2'd0, 16'hFFFF);
      reg_rd(2'd0, d); chk("R8 status write ignored", d, 16'h0000);
      pulse(9'h001);
      reg_wr(2'd0, 16'h0000);
      reg_rd(2'd0, d); chk("R8 status write keeps flag", d, 16'h0008);
      reg_rd(2'd2, d); chk("R8 clear reads zero", d, 16'h0000);
      reg_rd(2'd3, d); chk("R8 spare reads zero", d, 16'h0000);
      tidy();
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_levels();
      t_sticky();
      t_clear();
      t_race();
      t_enable();
      t_irq();
      t_suspend();
      t_status_write();
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule